// File: doc/BRIEF.md
# Servo Pulse-Width Generator

This block drives a single hobby-servo control line from an angle command. In servo mode it repeats a fixed 20 ms frame and, at the start of each frame, raises its output for a time that grows linearly from 1 ms at 0 degrees to 2 ms at 180 degrees. A second mode turns the same line into a plain 8-bit duty-cycle PWM. In that mode the period is 255 steps long and the code sets how many steps are high.

The command comes in on three inputs: a mode select, an 8-bit level, and an enable. The generator samples mode and level only on the clock edge that opens a new frame, so a pulse that is already running is never shortened or stretched. A one-cycle strobe marks the first cycle of every frame, so surrounding logic can line up command updates with frame edges. All timing is derived from the clock frequency parameter.

Top module: `servo_pwm_gen`

## Requirements
- R1: With mode select 0 (servo), every frame lasts CLK_HZ/50 clock cycles, which is 20 ms.
- R2: In servo mode with angle A in 0..180, the output is high for MIN + floor(A*MIN/180) cycles at the start of the frame, where MIN = CLK_HZ/1000 (1 ms). So 0 gives 1 ms, 90 gives 1.5 ms and 180 gives 2 ms.
- R3: In servo mode, an angle code above 180 produces the same pulse as 180.
- R4: With mode select 1 (duty), every frame lasts 255*DUTY_DIV cycles and the output is high for code*DUTY_DIV cycles at the start of the frame.
- R5: Duty code 255 keeps the output high through whole frames and across frame boundaries, with no low cycle. Duty code 0 never raises the output.
- R6: Mode and level are sampled only on the clock edge that begins a frame. A change in the middle of a frame does not alter that frame's length or pulse width, and it takes effect from the next frame.
- R7: frame_start is high for exactly one cycle, the first cycle of each frame. A non-empty pulse begins in that same cycle, and the output never rises in any other cycle.
- R8: While enable is low, the output and frame_start are low from the next cycle onward and the frame counter is cleared. The first clock edge that samples enable high starts a new frame, so frame_start is high in the following cycle.
- R9: Synchronous active-high reset drives the output and frame_start low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low holds the output low and clears the frame |
| mode_sel | input | 1 | 0 = servo angle mode, 1 = 8-bit duty mode |
| level_in | input | 8 | Angle (0..180) or duty code (0..255) |
| pwm_out | output | 1 | Pulse output |
| frame_start | output | 1 | One-cycle strobe in the first cycle of each frame |

## Verification
A corrupted frame counter or length register shows up as a strobe spacing that differs from 20 ms or 255 steps, and this is visible at the very next frame_start. A wrong latched pulse length shows up as a high run of the wrong width within the same frame. A sampling window that is leaking lets a mid-frame command change alter the pulse count of the frame in progress, which exposes it within one frame. A sequencer that is not cleared by enable or reset shows up as a high output or a strobe in the cycle after enable falls.

// File: rtl/servo_pwm_pkg.sv
package servo_pwm_pkg;

    typedef enum logic {
        MODE_SERVO = 1'b0,
        MODE_DUTY  = 1'b1
    } pwm_mode_e;

    localparam int unsigned ANGLE_MAX  = 180;
    localparam int unsigned DUTY_STEPS = 255;
    localparam int unsigned FRAMES_PER_SEC = 50;
    localparam int unsigned MS_PER_SEC     = 1000;

    typedef struct packed {
        pwm_mode_e  mode;
        logic [7:0] level;
    } pwm_cmd_t;

    function automatic logic [7:0] clamp_angle(input logic [7:0] a);
        return (32'(a) > ANGLE_MAX) ? 8'(ANGLE_MAX) : a;
    endfunction

    function automatic int unsigned servo_frame_cycles(input int unsigned clk_hz);
        return clk_hz / FRAMES_PER_SEC;
    endfunction

    function automatic int unsigned one_ms_cycles(input int unsigned clk_hz);
        return clk_hz / MS_PER_SEC;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spg_level_map.sv
module spg_level_map
    import servo_pwm_pkg::*;
#(
    parameter int unsigned CNT_W       = 20,
    parameter int unsigned SERVO_FRAME = 1000000,
    parameter int unsigned SERVO_MIN   = 50000,
    parameter int unsigned DUTY_DIV    = 196
) (
    input  pwm_cmd_t          cmd,
    output logic [CNT_W-1:0]  high_len,
    output logic [CNT_W-1:0]  frame_len
);
    localparam int unsigned DUTY_FRAME = DUTY_STEPS * DUTY_DIV;

    logic [7:0]  angle;
    logic [31:0] span_prod;
    logic [31:0] servo_high;
    logic [31:0] duty_high;

    always_comb begin
        angle      = clamp_angle(cmd.level);
        span_prod  = 32'(angle) * SERVO_MIN;
        servo_high = SERVO_MIN + span_prod / ANGLE_MAX;
        duty_high  = 32'(cmd.level) * DUTY_DIV;
        if (cmd.mode == MODE_SERVO) begin
            high_len  = CNT_W'(servo_high);
            frame_len = CNT_W'(SERVO_FRAME);
        end else begin
            high_len  = CNT_W'(duty_high);
            frame_len = CNT_W'(DUTY_FRAME);
        end
    end

endmodule

// File: rtl/spg_frame_seq.sv
module spg_frame_seq #(
    parameter int unsigned CNT_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [CNT_W-1:0]  next_high,
    input  logic [CNT_W-1:0]  next_len,
    output logic              pulse,
    output logic              strobe
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cur_high;
    logic [CNT_W-1:0] cur_len;
    logic             running;
    logic             frame_open;

    always_comb begin
        cnt_inc    = cnt + 1'b1;
        frame_open = !running || (cnt == cur_len - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt      <= '0;
            cur_high <= '0;
            cur_len  <= '1;
            running  <= 1'b0;
            pulse    <= 1'b0;
            strobe   <= 1'b0;
        end else if (frame_open) begin
            cnt      <= '0;
            cur_high <= next_high;
            cur_len  <= next_len;
            running  <= 1'b1;
            pulse    <= (next_high != '0);
            strobe   <= 1'b1;
        end else begin
            cnt      <= cnt_inc;
            pulse    <= (cnt_inc < cur_high);
            strobe   <= 1'b0;
        end
    end

endmodule

// File: rtl/servo_pwm_gen.sv
module servo_pwm_gen
    import servo_pwm_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50000000,
    parameter int unsigned DUTY_DIV = ((CLK_HZ / 255000) > 0) ? (CLK_HZ / 255000) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       mode_sel,
    input  logic [7:0] level_in,
    output logic       pwm_out,
    output logic       frame_start
);
    localparam int unsigned SERVO_FRAME = servo_frame_cycles(CLK_HZ);
    localparam int unsigned SERVO_MIN   = one_ms_cycles(CLK_HZ);
    localparam int unsigned DUTY_FRAME  = DUTY_STEPS * DUTY_DIV;
    localparam int unsigned LONGEST     = max_u(SERVO_FRAME, DUTY_FRAME);
    localparam int unsigned CNT_W       = $clog2(LONGEST + 1);

    pwm_cmd_t          cmd;
    logic [CNT_W-1:0]  map_high;
    logic [CNT_W-1:0]  map_len;

    always_comb begin
        cmd.mode  = pwm_mode_e'(mode_sel);
        cmd.level = level_in;
    end

    spg_level_map #(
        .CNT_W      (CNT_W),
        .SERVO_FRAME(SERVO_FRAME),
        .SERVO_MIN  (SERVO_MIN),
        .DUTY_DIV   (DUTY_DIV)
    ) u_map (
        .cmd      (cmd),
        .high_len (map_high),
        .frame_len(map_len)
    );

    spg_frame_seq #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .next_high(map_high),
        .next_len (map_len),
        .pulse    (pwm_out),
        .strobe   (frame_start)
    );

endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
    parameter int unsigned CLK_HZ   = 50000000,
    parameter int unsigned DUTY_DIV = 196
) (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic mode_sel,
    input logic pwm_out,
    input logic frame_start
);
    localparam int unsigned FRAME_LEN = CLK_HZ / 50;
    localparam int unsigned DUTY_LEN  = 255 * DUTY_DIV;

    logic        mode_d;
    logic        rec_mode;
    logic        valid;
    logic [31:0] run_len;
    logic        rst_d;

    always_ff @(posedge clk) begin
        mode_d <= mode_sel;
        rst_d  <= rst;
        if (rst || !enable) begin
            valid    <= 1'b0;
            run_len  <= '0;
            rec_mode <= 1'b0;
        end else if (frame_start) begin
            valid    <= 1'b1;
            run_len  <= 32'd1;
            rec_mode <= mode_d;
        end else begin
            run_len  <= run_len + 32'd1;
        end
    end

    // R1 / R4: spacing between consecutive strobes matches the latched mode
    a_r1_frame_length: assert property (@(posedge clk) disable iff (rst)
        (frame_start && valid && enable) |-> (run_len == (rec_mode ? DUTY_LEN : FRAME_LEN)));

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    a_r7_rise_at_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> frame_start);

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pwm_out && !frame_start));

    always @(posedge clk) begin
        if (rst_d === 1'b1) begin
            a_r9_reset_low: assert (!pwm_out && !frame_start);
        end
    end

endmodule

bind servo_pwm_gen spg_checker #(
    .CLK_HZ  (CLK_HZ),
    .DUTY_DIV(DUTY_DIV)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .mode_sel   (mode_sel),
    .pwm_out    (pwm_out),
    .frame_start(frame_start)
);

// File: tb/servo_pwm_gen_bench.sv
module servo_pwm_gen_bench;
    localparam int unsigned CLK_HZ   = 90000;
    localparam int unsigned DUTY_DIV = 1;
    localparam int FRAME = CLK_HZ / 50;
    localparam int MINC  = CLK_HZ / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       mode_sel = 1'b0;
    logic [7:0] level_in = 8'd0;
    logic       pwm_out;
    logic       frame_start;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    servo_pwm_gen #(.CLK_HZ(CLK_HZ), .DUTY_DIV(DUTY_DIV)) u_servo_pwm_gen (
        .clk(clk), .rst(rst), .enable(enable), .mode_sel(mode_sel),
        .level_in(level_in), .pwm_out(pwm_out), .frame_start(frame_start)
    );

    function automatic int exp_high(input logic m, input int lvl);
        int a;
        if (m) return lvl * DUTY_DIV;
        a = (lvl > 180) ? 180 : lvl;
        return MINC + (a * MINC) / 180;
    endfunction

    function automatic int exp_len(input logic m);
        return m ? 255 * DUTY_DIV : FRAME;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // assumes the current negedge sits in a frame_start cycle
    task automatic measure(input int chg_at, input logic cm, input logic [7:0] cl,
                           output int len, output int hi, output int first);
        len = 0; hi = 0; first = int'(pwm_out);
        do begin
            if (len == chg_at) begin mode_sel = cm; level_in = cl; end
            hi += int'(pwm_out);
            len++;
            @(negedge clk);
        end while (!frame_start && len < 10000);
    endtask

    task automatic wait_strobe();
        int n = 0;
        while (!frame_start && n < 10000) begin @(negedge clk); n++; end
    endtask

    task automatic run_frame(input string req, input logic m, input logic [7:0] lvl);
        int len, hi, first;
        wait_strobe();
        mode_sel = m; level_in = lvl;
        @(negedge clk);
        wait_strobe();
        measure(-1, m, lvl, len, hi, first);
        chk({req, " length"}, len, exp_len(m));
        chk({req, " high"}, hi, exp_high(m, int'(lvl)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len, hi, first;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R9 reset state
        chk("R9 out in reset", int'(pwm_out), 0);
        chk("R9 strobe in reset", int'(frame_start), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 out while disabled", int'(pwm_out), 0);
        chk("R8 strobe while disabled", int'(frame_start), 0);

        // first enable: strobe in the cycle after the sampling edge
        mode_sel = 1'b0; level_in = 8'd90;
        enable = 1'b1;
        @(negedge clk);
        chk("R8 first strobe after enable", int'(frame_start), 1);
        chk("R7 pulse starts with frame", int'(pwm_out), 1);
        measure(-1, 1'b0, 8'd0, len, hi, first);
        chk("R1 servo frame length", len, FRAME);
        chk("R2 servo 90 high", hi, exp_high(1'b0, 90));

        run_frame("R2 servo 0", 1'b0, 8'd0);
        run_frame("R2 servo 180", 1'b0, 8'd180);
        run_frame("R2 servo 45", 1'b0, 8'd45);
        run_frame("R3 servo 181 clamp", 1'b0, 8'd181);
        run_frame("R3 servo 255 clamp", 1'b0, 8'd255);
        run_frame("R4 duty 128", 1'b1, 8'd128);
        run_frame("R4 duty 1", 1'b1, 8'd1);
        run_frame("R5 duty 0", 1'b1, 8'd0);
        run_frame("R5 duty 255", 1'b1, 8'd255);
        // R5 continuity across boundary: still high in the next strobe cycle
        chk("R5 high across boundary", int'(pwm_out), 1);

        // R6 mid-frame change of level and mode
        wait_strobe();
        mode_sel = 1'b0; level_in = 8'd0;
        @(negedge clk);
        wait_strobe();
        measure(5, 1'b1, 8'd200, len, hi, first);
        chk("R6 frame unaffected length", len, FRAME);
        chk("R6 frame unaffected high", hi, exp_high(1'b0, 0));
        chk("R7 pulse at frame start", first, 1);
        measure(-1, 1'b1, 8'd200, len, hi, first);
        chk("R6 change applied length", len, exp_len(1'b1));
        chk("R6 change applied high", hi, 200);

        // R8 disable in the middle of a frame
        mode_sel = 1'b0; level_in = 8'd120;
        @(negedge clk);
        wait_strobe();
        repeat (10) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 out low after disable", int'(pwm_out), 0);
        chk("R8 strobe low after disable", int'(frame_start), 0);
        hi = 0;
        for (int i = 0; i < 30; i++) begin
            hi += int'(pwm_out) + int'(frame_start);
            @(negedge clk);
        end
        chk("R8 quiet while disabled", hi, 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R8 strobe after re-enable", int'(frame_start), 1);
        measure(-1, 1'b0, 8'd0, len, hi, first);
        chk("R8 fresh frame length", len, FRAME);
        chk("R8 fresh frame high", hi, exp_high(1'b0, 120));

        // constrained random mix
        for (int k = 0; k < 12; k++) begin
            logic       rm;
            logic [7:0] rl;
            rm = 1'($urandom % 2);
            rl = 8'($urandom % 256);
            if (rm) run_frame("R4 random duty", rm, rl);
            else    run_frame("R2 random servo", rm, rl);
        end

        // R9 reset mid-run
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 out after reset", int'(pwm_out), 0);
        chk("R9 strobe after reset", int'(frame_start), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule